// File: doc/BRIEF.md
# Four-Channel Polarimetric Correlator

This block forms the raw correlation sums for a fully polarimetric radiometer. Four 8-bit signal channels arrive together on every fabric clock: vertical in-phase, vertical quadrature, horizontal in-phase and horizontal quadrature. Each channel arrives as one 32-bit word that holds four consecutive samples, so the fabric clock runs at a quarter of the sample rate. In one clock, each of four product lanes multiplies all four sample positions, sums them, and registers the result. One lane serves each correlation term: vertical power, horizontal power, the in-phase cross term and the quadrature cross term.

Four 48-bit accumulators add up the lane results over an integration period whose length is set in counted fabric clocks. When a period ends, all four sums are copied into shadow registers in the same cycle and the accumulators restart from zero. A byte serializer then sends the snapshot as a frame over a valid/ready handshake to a UART transmitter. The frame holds a header byte, the four sums with the most significant byte first, and a checksum byte. The serializer state machine has four states. SER_IDLE goes to SER_HEAD when a snapshot is ready. SER_HEAD goes to SER_BODY when the header is accepted. SER_BODY goes to SER_CSUM when the 24th data byte is accepted. SER_CSUM goes back to SER_IDLE when the checksum is accepted.

Top module: `pol_correlator`

## Requirements
- R1: Each sample is offset binary and becomes two's complement by inverting its MSB. A sample of 0x80 therefore contributes zero to every sum.
- R2: Sample k of a channel word sits in bits [8k+7:8k], k = 0..3. All four positions contribute to every sum in the same clock.
- R3: The power sums are pow_v = Σ(vi² + vq²) and pow_h = Σ(hi² + hq²).
- R4: The cross sums are cross_i = Σ(vi·hi + vq·hq) and cross_q = Σ(vi·hq − vq·hi).
- R5: A period spans `int_len` clocks in which `in_valid` is high. Clocks with `in_valid` low are not counted and add nothing. A value of 0 acts as 1. `int_len` may change only between periods.
- R6: At the end of a period all four sums are latched together and the accumulators restart at zero, so the next period contains only its own samples.
- R7: A frame is the header 0xA5, then 24 bytes in the order pow_v, pow_h, cross_i, cross_q. Each sum is sent as a 48-bit two's complement value, most significant byte first.
- R8: The last frame byte is the low 8 bits of the arithmetic sum of the 24 data bytes.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R10: If periods end while a frame is being sent, only the most recent snapshot is sent after the current frame. `tx_valid` drops for exactly one clock between frames.
- R11: After reset `tx_valid` is low, and no frame appears until a period has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, one quarter of the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The four channel words in this clock are counted |
| ch_vi | input | 32 | Vertical in-phase, four samples |
| ch_vq | input | 32 | Vertical quadrature, four samples |
| ch_hi | input | 32 | Horizontal in-phase, four samples |
| ch_hq | input | 32 | Horizontal quadrature, four samples |
| int_len | input | 16 | Integration length in counted clocks |
| tx_data | output | 8 | Frame byte offered to the UART transmitter |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_ready | input | 1 | The transmitter accepts the byte in this clock |

## Verification
The bench uses the default parameters: 8-bit samples, four samples per word, 48-bit accumulators and a 16-bit length field. It drives integration lengths of 0 to 6 clocks, which keeps each period much shorter than a 26-byte frame. With periods that short, the bench can line up several completed snapshots behind a stalled frame and so reach the overrun case of R10. With full-scale samples of 0xFF and 0x00, both the negative and the positive product extremes reach the lane adder, and negative cross sums exercise sign extension in all six bytes of a sum.

// File: rtl/pol_corr_pkg.sv
package pol_corr_pkg;
    // Correlation terms, in frame order
    localparam int N_TERMS = 4;
    localparam int T_POW_V = 0;
    localparam int T_POW_H = 1;
    localparam int T_XI    = 2;
    localparam int T_XQ    = 3;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_HEAD,
        SER_BODY,
        SER_CSUM
    } ser_state_t;
endpackage

// File: rtl/corr_lane.sv
// One product lane: sum over all sample positions of a0*b0 +/- a1*b1.
module corr_lane #(
    parameter int SAMPLE_W = 8,
    parameter int SAMPLES  = 4,
    parameter bit SUB      = 1'b0,
    parameter int LANE_W   = 2 * SAMPLE_W + $clog2(2 * SAMPLES) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SAMPLES*SAMPLE_W-1:0]  a0,
    input  logic [SAMPLES*SAMPLE_W-1:0]  b0,
    input  logic [SAMPLES*SAMPLE_W-1:0]  a1,
    input  logic [SAMPLES*SAMPLE_W-1:0]  b1,
    output logic signed [LANE_W-1:0]     sum_o
);
    localparam int PROD_W = 2 * SAMPLE_W;

    function automatic logic signed [SAMPLE_W-1:0] to_tc(input logic [SAMPLE_W-1:0] x);
        return {~x[SAMPLE_W-1], x[SAMPLE_W-2:0]};
    endfunction

    logic signed [PROD_W-1:0] p0_q [SAMPLES];
    logic signed [PROD_W-1:0] p1_q [SAMPLES];

    always_ff @(posedge clk) begin
        for (int k = 0; k < SAMPLES; k++) begin
            if (!rst_n) begin
                p0_q[k] <= '0;
                p1_q[k] <= '0;
            end else begin
                p0_q[k] <= PROD_W'(to_tc(a0[k*SAMPLE_W +: SAMPLE_W])) *
                           PROD_W'(to_tc(b0[k*SAMPLE_W +: SAMPLE_W]));
                p1_q[k] <= PROD_W'(to_tc(a1[k*SAMPLE_W +: SAMPLE_W])) *
                           PROD_W'(to_tc(b1[k*SAMPLE_W +: SAMPLE_W]));
            end
        end
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < SAMPLES; k++) begin
            sum_o = sum_o + LANE_W'(p0_q[k]);
            if (SUB) sum_o = sum_o - LANE_W'(p1_q[k]);
            else     sum_o = sum_o + LANE_W'(p1_q[k]);
        end
    end
endmodule

// File: rtl/corr_accum.sv
// Period accumulators with a shadow snapshot taken in one cycle.
module corr_accum #(
    parameter int N_TERMS = 4,
    parameter int LANE_W  = 20,
    parameter int ACC_W   = 48,
    parameter int LEN_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic signed [LANE_W-1:0] lane_sum [N_TERMS],
    input  logic [LEN_W-1:0]         int_len,
    output logic [ACC_W-1:0]         shadow_o [N_TERMS],
    output logic                     snap_o
);
    logic signed [ACC_W-1:0] acc_q [N_TERMS];
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_m1;
    logic             last;

    assign len_m1 = (int_len == '0) ? '0 : int_len - LEN_W'(1);
    assign last   = valid_i && (cnt_q >= len_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_o <= 1'b0;
            for (int i = 0; i < N_TERMS; i++) begin
                acc_q[i]    <= '0;
                shadow_o[i] <= '0;
            end
        end else begin
            snap_o <= last;
            if (valid_i) begin
                cnt_q <= last ? '0 : cnt_q + LEN_W'(1);
                for (int i = 0; i < N_TERMS; i++) begin
                    if (last) begin
                        shadow_o[i] <= acc_q[i] + ACC_W'(lane_sum[i]);
                        acc_q[i]    <= '0;
                    end else begin
                        acc_q[i]    <= acc_q[i] + ACC_W'(lane_sum[i]);
                    end
                end
            end
        end
    end

    // R5: a snapshot only follows a counted clock
    a_r5_snap_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        snap_o |-> $past(valid_i));

    for (genvar i = 0; i < N_TERMS; i++) begin : g_chk
        // R5: uncounted clocks leave the running sums alone
        a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> $stable(acc_q[i]));
        // R6: the snapshot moves only together with the end-of-period pulse
        a_r6_shadow_on_snap: assert property (@(posedge clk) disable iff (!rst_n)
            !snap_o |-> $stable(shadow_o[i]));
    end
endmodule

// File: rtl/corr_serializer.sv
// Frames the snapshot as header, data bytes MSB first, checksum.
module corr_serializer
    import pol_corr_pkg::*;
#(
    parameter int         N_TERMS = 4,
    parameter int         ACC_W   = 48,
    parameter logic [7:0] HEADER  = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [ACC_W-1:0] shadow_i [N_TERMS],
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready
);
    localparam int FRAME_W = N_TERMS * ACC_W;
    localparam int NB      = FRAME_W / 8;
    localparam int IDX_W   = $clog2(NB);

    ser_state_t state_q, state_d;
    logic [FRAME_W-1:0] frame_q, frame_in;
    logic [IDX_W-1:0]   idx_q;
    logic [7:0]         csum_q;
    logic               pending_q;
    logic               start, accept;

    always_comb begin
        for (int i = 0; i < N_TERMS; i++)
            frame_in[(N_TERMS-1-i)*ACC_W +: ACC_W] = shadow_i[i];
    end

    assign start  = (state_q == SER_IDLE) && (snap_i || pending_q);
    assign accept = tx_valid && tx_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SER_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE: if (start)  state_d = SER_HEAD;
            SER_HEAD: if (accept) state_d = SER_BODY;
            SER_BODY: if (accept && idx_q == IDX_W'(NB-1)) state_d = SER_CSUM;
            SER_CSUM: if (accept) state_d = SER_IDLE;
            default:              state_d = SER_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b1;
        tx_data  = 8'h00;
        unique case (state_q)
            SER_IDLE: tx_valid = 1'b0;
            SER_HEAD: tx_data  = HEADER;
            SER_BODY: tx_data  = frame_q[FRAME_W-1 -: 8];
            SER_CSUM: tx_data  = csum_q;
            default:  tx_valid = 1'b0;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            idx_q     <= '0;
            csum_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            if (start) begin
                frame_q   <= frame_in;
                idx_q     <= '0;
                csum_q    <= '0;
                pending_q <= 1'b0;
            end else if (snap_i) begin
                pending_q <= 1'b1;
            end
            if (state_q == SER_BODY && accept) begin
                frame_q <= frame_q << 8;
                idx_q   <= idx_q + IDX_W'(1);
                csum_q  <= csum_q + frame_q[FRAME_W-1 -: 8];
            end
        end
    end

    // R9: an offered byte waits unchanged for the transmitter
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    // R7: every frame opens with the header
    a_r7_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == HEADER);
    // R10: one idle clock separates frames
    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        accept && state_q == SER_CSUM |=> !tx_valid);
endmodule

// File: rtl/pol_correlator.sv
module pol_correlator
    import pol_corr_pkg::*;
#(
    parameter int         SAMPLE_W = 8,
    parameter int         SAMPLES  = 4,
    parameter int         ACC_W    = 48,
    parameter int         LEN_W    = 16,
    parameter logic [7:0] HEADER   = 8'hA5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [SAMPLES*SAMPLE_W-1:0] ch_vi,
    input  logic [SAMPLES*SAMPLE_W-1:0] ch_vq,
    input  logic [SAMPLES*SAMPLE_W-1:0] ch_hi,
    input  logic [SAMPLES*SAMPLE_W-1:0] ch_hq,
    input  logic [LEN_W-1:0]            int_len,
    output logic [7:0]                  tx_data,
    output logic                        tx_valid,
    input  logic                        tx_ready
);
    localparam int LANE_W = 2 * SAMPLE_W + $clog2(2 * SAMPLES) + 1;

    logic signed [LANE_W-1:0] lane_sum [N_TERMS];
    logic [ACC_W-1:0]         shadow [N_TERMS];
    logic                     valid_q, snap;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    corr_lane #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .SUB(1'b0), .LANE_W(LANE_W)) u_pow_v (
        .clk(clk), .rst_n(rst_n), .a0(ch_vi), .b0(ch_vi), .a1(ch_vq), .b1(ch_vq),
        .sum_o(lane_sum[T_POW_V]));
    corr_lane #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .SUB(1'b0), .LANE_W(LANE_W)) u_pow_h (
        .clk(clk), .rst_n(rst_n), .a0(ch_hi), .b0(ch_hi), .a1(ch_hq), .b1(ch_hq),
        .sum_o(lane_sum[T_POW_H]));
    corr_lane #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .SUB(1'b0), .LANE_W(LANE_W)) u_xi (
        .clk(clk), .rst_n(rst_n), .a0(ch_vi), .b0(ch_hi), .a1(ch_vq), .b1(ch_hq),
        .sum_o(lane_sum[T_XI]));
    corr_lane #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .SUB(1'b1), .LANE_W(LANE_W)) u_xq (
        .clk(clk), .rst_n(rst_n), .a0(ch_vi), .b0(ch_hq), .a1(ch_vq), .b1(ch_hi),
        .sum_o(lane_sum[T_XQ]));

    corr_accum #(.N_TERMS(N_TERMS), .LANE_W(LANE_W), .ACC_W(ACC_W), .LEN_W(LEN_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_q), .lane_sum(lane_sum),
        .int_len(int_len), .shadow_o(shadow), .snap_o(snap));

    corr_serializer #(.N_TERMS(N_TERMS), .ACC_W(ACC_W), .HEADER(HEADER)) u_ser (
        .clk(clk), .rst_n(rst_n), .snap_i(snap), .shadow_i(shadow),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));
endmodule

// File: tb/pol_correlator_test.sv
module pol_correlator_test;
    localparam logic [7:0] HDR = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] ch_vi = '0, ch_vq = '0, ch_hi = '0, ch_hq = '0;
    logic [15:0] int_len = 16'd1;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;

    always #10 clk = ~clk;

    pol_correlator uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch_vi(ch_vi), .ch_vq(ch_vq), .ch_hi(ch_hi), .ch_hq(ch_hq),
        .int_len(int_len), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

    logic [7:0] exp_q[$];
    string      tag_q[$];
    int n_chk = 0, n_fail = 0;
    int ready_mode = 2;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sv(input logic [7:0] b);
        logic signed [7:0] s;
        s = {~b[7], b[6:0]};
        return int'(s);
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push_frame(input longint s[4], input string tag);
        logic [47:0] t;
        logic [7:0]  cs, by;
        cs = 8'h00;
        exp_q.push_back(HDR); tag_q.push_back("R7 header");
        for (int i = 0; i < 4; i++) begin
            t = s[i][47:0];
            for (int j = 0; j < 6; j++) begin
                by = t[47-8*j -: 8];
                cs = cs + by;
                exp_q.push_back(by); tag_q.push_back(tag);
            end
        end
        exp_q.push_back(cs); tag_q.push_back("R8 checksum");
    endtask

    // pattern 0: all 0x80, 1: full-scale constants, 2: random
    task automatic run_period(input int len_cfg, input int pat, input bit gaps,
                              input bit expect_frame, input string tag);
        longint s[4];
        int L, a, b, c, d;
        L = (len_cfg == 0) ? 1 : len_cfg;
        for (int i = 0; i < 4; i++) s[i] = 0;
        in_valid = 1'b0;
        tick(); tick();
        int_len = 16'(len_cfg);
        tick();
        for (int n = 0; n < L; n++) begin
            if (gaps && ($urandom_range(0, 1) == 1)) begin
                in_valid = 1'b0;
                ch_vi = $urandom; ch_vq = $urandom; ch_hi = $urandom; ch_hq = $urandom;
                tick();
            end
            case (pat)
                0: begin ch_vi = {4{8'h80}}; ch_vq = {4{8'h80}}; ch_hi = {4{8'h80}}; ch_hq = {4{8'h80}}; end
                1: begin ch_vi = {4{8'hFF}}; ch_vq = {4{8'h00}}; ch_hi = {4{8'h00}}; ch_hq = {4{8'hFF}}; end
                default: begin ch_vi = $urandom; ch_vq = $urandom; ch_hi = $urandom; ch_hq = $urandom; end
            endcase
            for (int k = 0; k < 4; k++) begin
                a = sv(ch_vi[8*k +: 8]); b = sv(ch_vq[8*k +: 8]);
                c = sv(ch_hi[8*k +: 8]); d = sv(ch_hq[8*k +: 8]);
                s[0] += longint'(a*a + b*b);
                s[1] += longint'(c*c + d*d);
                s[2] += longint'(a*c + b*d);
                s[3] += longint'(a*d - b*c);
            end
            in_valid = 1'b1;
            tick();
        end
        in_valid = 1'b0;
        if (expect_frame) push_frame(s, tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) tick();
        tick(); tick();
    endtask

    // Ready driver
    always @(posedge clk) begin
        #2;
        case (ready_mode)
            0: tx_ready <= 1'b1;
            1: tx_ready <= 1'($urandom_range(0, 1));
            default: tx_ready <= 1'b0;
        endcase
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(tx_valid && tx_data == prev_data, "R9 hold", {tx_valid, tx_data}, {1'b1, prev_data});
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected byte", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(tx_data == e, t, tx_data, e);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (10) tick();
        // R11: idle after reset, nothing offered before a period ends
        check(tx_valid == 1'b0, "R11 reset idle", tx_valid, 0);
        ready_mode = 0;
        run_period(3, 0, 0, 1, "R1 mid-scale zero");  drain();
        run_period(4, 1, 0, 1, "R3 R4 full-scale");   drain();
        ready_mode = 1;
        run_period(5, 2, 0, 1, "R2 R3 R4 random");    drain();
        run_period(6, 2, 1, 1, "R5 gapped period");   drain();
        run_period(0, 2, 0, 1, "R5 zero length");     drain();
        // R6: back-to-back periods, each frame holds only its own samples
        run_period(2, 2, 0, 1, "R6 first");
        run_period(2, 1, 0, 1, "R6 second");          drain();
        // R10: stall output while three periods end; middle snapshot superseded
        ready_mode = 2;
        run_period(3, 2, 0, 1, "R10 first");
        repeat (3) tick();
        run_period(3, 2, 0, 0, "R10 dropped");
        run_period(4, 1, 0, 1, "R10 latest");
        repeat (5) tick();
        ready_mode = 1;
        drain();
        repeat (20) tick();
        check(tx_valid == 1'b0, "R10 no extra frame", tx_valid, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule